// File: doc/BRIEF.md
# CompactFlash Card Configuration Registers

This block holds the attribute-space configuration state of a CompactFlash or PC Card ATA device and produces the card's host interrupt. A byte-wide attribute port reaches two regions. Below the configuration base, a read is forwarded to an external Card Information Structure ROM. Reads past the end of the ROM return zero. At and above the base sit four byte registers on even offsets:
- option (mode and soft reset)
- configuration status
- pin replacement
- socket/copy

The task-file front end supplies two inputs: the device interrupt request, and writes of the two device-control bits that matter here (interrupt disable and soft reset). The block drives the host interrupt level. It also drives a one-cycle soft-reset pulse, which the front end uses to reset itself. Register writes take effect at the clock edge that samples the write strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `cf_cfg_regs`

## Requirements
- R1: A read at an attribute offset below CFG_BASE returns the CIS ROM byte (`cis_data_i` for `cis_addr_o` equal to the offset) when the offset is below CIS_LEN. Otherwise it returns 0x00. Read data appears on `attr_rdata_o` one cycle after `attr_rd_i`.
- R2: A write to the option register (CFG_BASE+0) with bit 7 clear stores the written byte ANDed with 0xCF. A read of CFG_BASE+0 returns that stored byte.
- R3: A write to the option register with bit 7 set causes a card soft reset: `soft_rst_o` is high for exactly the one cycle after the write edge, and option, status (except the interrupt bit), pin-ready and interrupt-disable state read back as zero.
- R4: A write to the status register (CFG_BASE+2) keeps the current bits 7 and 1 and loads bits 6, 5, 4 and 2 from the written byte. All other bits read 0. Bit 1 of the status register follows `dev_irq_i` with one cycle of delay.
- R5: A status write that changes bit 2 (power down) sets the pin-ready flag. A status write that leaves bit 2 unchanged does not set it.
- R6: While the interrupt-disable bit is set, a status read returns bit 1 as 0.
- R7: A read of the pin replacement register (CFG_BASE+4) returns 0x0C ORed with 0x20 when pin-ready is set. Writes to it do not change this value.
- R8: The socket/copy register (CFG_BASE+6) and any other offset at or above CFG_BASE read 0x00. Writes there change no register.
- R9: `host_irq_o` is high exactly when the registered device request (status bit 1) is 0, the interrupt-disable bit is 0, and option bit 7 is 0.
- R10: After `rst_ni` the option, status and pin-ready state are 0, interrupt disable is 0, `soft_rst_o` is 0 and `attr_rdata_o` is 0.
- R11: A device-control write (`ctrl_wr_i`) with `ctrl_srst_i` set causes the same soft reset and one-cycle `soft_rst_o` pulse as R3. With `ctrl_srst_i` clear, such a write loads `ctrl_nien_i` as the interrupt-disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| attr_addr_i | input | ADDR_W | Attribute byte offset |
| attr_rd_i | input | 1 | Attribute read strobe |
| attr_wr_i | input | 1 | Attribute write strobe |
| attr_wdata_i | input | 8 | Attribute write data |
| attr_rdata_o | output | 8 | Registered attribute read data |
| cis_addr_o | output | ADDR_W | CIS ROM address |
| cis_data_i | input | 8 | CIS ROM data, combinational from cis_addr_o |
| dev_irq_i | input | 1 | Device interrupt request from the task file |
| ctrl_wr_i | input | 1 | Device-control write strobe |
| ctrl_nien_i | input | 1 | Device-control interrupt-disable bit |
| ctrl_srst_i | input | 1 | Device-control soft-reset bit |
| host_irq_o | output | 1 | Host interrupt level |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
The bench keeps ADDR_W=12 and CFG_BASE=0x200 and sets CIS_LEN to 64. This leaves a wide gap between the end of the ROM and the register window, so reads there can be checked to return zero (R1). Because the ROM model returns each offset XOR 0xA5, every CIS byte is distinct. The bench also steps the power-down bit through unchanged and changed writes and toggles the device request under both interrupt-disable settings. It triggers soft reset from both sources.

// File: rtl/cf_cfg_pkg.sv
package cf_cfg_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CIS,
    SEL_OPT,
    SEL_STAT,
    SEL_PIN,
    SEL_SOCK
  } sel_e;

  // Register offsets relative to the configuration base
  localparam int unsigned OFF_OPT  = 0;
  localparam int unsigned OFF_STAT = 2;
  localparam int unsigned OFF_PIN  = 4;
  localparam int unsigned OFF_SOCK = 6;

  localparam logic [7:0] OPT_WMASK  = 8'hCF;
  localparam logic [7:0] STAT_KEEP  = 8'h82;
  localparam logic [7:0] STAT_LOAD  = 8'h74;
  localparam logic [7:0] PIN_FIXED  = 8'h0C;
  localparam logic [7:0] PIN_RDY    = 8'h20;

  localparam int unsigned OPT_SRST_BIT = 7;
  localparam int unsigned STAT_INT_BIT = 1;
  localparam int unsigned STAT_PD_BIT  = 2;

endpackage

// File: rtl/cf_cfg_decode.sv
module cf_cfg_decode
  import cf_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CFG_BASE = 'h200,
  parameter int unsigned CIS_LEN  = 'h14A
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CLEN_A = ADDR_W'(CIS_LEN);

  logic [ADDR_W-1:0] off;

  assign off = addr_i - BASE_A;

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i < BASE_A) begin
      if (addr_i < CLEN_A) sel_o = SEL_CIS;
    end else begin
      unique case (off)
        ADDR_W'(OFF_OPT):  sel_o = SEL_OPT;
        ADDR_W'(OFF_STAT): sel_o = SEL_STAT;
        ADDR_W'(OFF_PIN):  sel_o = SEL_PIN;
        ADDR_W'(OFF_SOCK): sel_o = SEL_SOCK;
        default:           sel_o = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cf_cfg_regfile.sv
module cf_cfg_regfile
  import cf_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  sel_e       sel_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       clr_i,
  input  logic       dev_irq_i,
  input  logic       ctrl_wr_i,
  input  logic       ctrl_nien_i,
  output logic [7:0] opt_o,
  output logic [7:0] stat_o,
  output logic       pin_rdy_o,
  output logic       nien_o
);

  logic [7:0] opt_q;
  logic [7:0] st_q;
  logic       int_q;
  logic       rdy_q;
  logic       nien_q;
  logic       wr_opt, wr_stat, pd_flip;

  assign wr_opt  = wr_i && (sel_i == SEL_OPT);
  assign wr_stat = wr_i && (sel_i == SEL_STAT);
  assign pd_flip = wdata_i[STAT_PD_BIT] ^ st_q[STAT_PD_BIT];

  // device request is sampled every cycle; only rst_ni clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_q <= 1'b0;
    else         int_q <= dev_irq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q  <= '0;
      st_q   <= '0;
      rdy_q  <= 1'b0;
      nien_q <= 1'b0;
    end else if (clr_i) begin
      opt_q  <= '0;
      st_q   <= '0;
      rdy_q  <= 1'b0;
      nien_q <= 1'b0;
    end else begin
      if (wr_opt) opt_q <= wdata_i & OPT_WMASK;
      if (wr_stat) begin
        st_q <= (st_q & STAT_KEEP) | (wdata_i & STAT_LOAD);
        if (pd_flip) rdy_q <= 1'b1;
      end
      if (ctrl_wr_i) nien_q <= ctrl_nien_i;
    end
  end

  always_comb begin
    stat_o               = st_q;
    stat_o[STAT_INT_BIT] = int_q;
  end

  assign opt_o     = opt_q;
  assign pin_rdy_o = rdy_q;
  assign nien_o    = nien_q;

endmodule

// File: rtl/cf_cfg_irq.sv
module cf_cfg_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stat_int_i,
  input  logic nien_i,
  input  logic opt_srst_i,
  input  logic srst_req_i,
  output logic host_irq_o,
  output logic soft_rst_o
);

  logic srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else         srst_q <= srst_req_i;
  end

  // status interrupt bit is active low toward the host
  assign host_irq_o = !stat_int_i && !nien_i && !opt_srst_i;
  assign soft_rst_o = srst_q;

endmodule

// File: rtl/cf_cfg_regs.sv
module cf_cfg_regs
  import cf_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CFG_BASE = 'h200,
  parameter int unsigned CIS_LEN  = 'h14A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] attr_addr_i,
  input  logic              attr_rd_i,
  input  logic              attr_wr_i,
  input  logic [7:0]        attr_wdata_i,
  output logic [7:0]        attr_rdata_o,
  output logic [ADDR_W-1:0] cis_addr_o,
  input  logic [7:0]        cis_data_i,
  input  logic              dev_irq_i,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_nien_i,
  input  logic              ctrl_srst_i,
  output logic              host_irq_o,
  output logic              soft_rst_o
);

  sel_e       sel;
  logic [7:0] opt_q;
  logic [7:0] stat_q;
  logic       pin_rdy_q;
  logic       nien_q;
  logic       srst_req;
  logic [7:0] rd_next;
  logic [7:0] rdata_q;

  cf_cfg_decode #(
    .ADDR_W  (ADDR_W),
    .CFG_BASE(CFG_BASE),
    .CIS_LEN (CIS_LEN)
  ) u_decode (
    .addr_i(attr_addr_i),
    .sel_o (sel)
  );

  assign srst_req = (attr_wr_i && (sel == SEL_OPT) && attr_wdata_i[OPT_SRST_BIT])
                 || (ctrl_wr_i && ctrl_srst_i);

  cf_cfg_regfile u_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .wr_i       (attr_wr_i),
    .wdata_i    (attr_wdata_i),
    .clr_i      (srst_req),
    .dev_irq_i  (dev_irq_i),
    .ctrl_wr_i  (ctrl_wr_i),
    .ctrl_nien_i(ctrl_nien_i),
    .opt_o      (opt_q),
    .stat_o     (stat_q),
    .pin_rdy_o  (pin_rdy_q),
    .nien_o     (nien_q)
  );

  cf_cfg_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stat_int_i(stat_q[STAT_INT_BIT]),
    .nien_i    (nien_q),
    .opt_srst_i(opt_q[OPT_SRST_BIT]),
    .srst_req_i(srst_req),
    .host_irq_o(host_irq_o),
    .soft_rst_o(soft_rst_o)
  );

  assign cis_addr_o = attr_addr_i;

  always_comb begin
    rd_next = 8'h00;
    unique case (sel)
      SEL_CIS:  rd_next = cis_data_i;
      SEL_OPT:  rd_next = opt_q;
      SEL_STAT: rd_next = nien_q ? (stat_q & ~(8'h01 << STAT_INT_BIT)) : stat_q;
      SEL_PIN:  rd_next = PIN_FIXED | (pin_rdy_q ? PIN_RDY : 8'h00);
      default:  rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (attr_rd_i) rdata_q <= rd_next;
  end

  assign attr_rdata_o = rdata_q;

endmodule

// File: rtl/cf_cfg_regs_chk.sv
module cf_cfg_regs_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CFG_BASE = 'h200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] attr_addr_i,
  input logic              attr_rd_i,
  input logic              attr_wr_i,
  input logic [7:0]        attr_wdata_i,
  input logic [7:0]        attr_rdata_o,
  input logic              dev_irq_i,
  input logic              ctrl_wr_i,
  input logic              ctrl_srst_i,
  input logic              host_irq_o,
  input logic              soft_rst_o,
  input logic [7:0]        opt_q,
  input logic [7:0]        stat_q,
  input logic              pin_rdy_q
);

  localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(CFG_BASE + 2);
  localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(CFG_BASE + 4);
  localparam logic [ADDR_W-1:0] A_SOCK = ADDR_W'(CFG_BASE + 6);

  logic ctrl_clr;
  assign ctrl_clr = ctrl_wr_i && ctrl_srst_i;

  AST_SRST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o); // R3

  AST_SRST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_o) |-> ($past(attr_wr_i && attr_addr_i == A_OPT && attr_wdata_i[7])
                          || $past(ctrl_clr))); // R11

  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (opt_q == 8'h00 && !pin_rdy_q)); // R3

  AST_OPT_WMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attr_wr_i && attr_addr_i == A_OPT && !attr_wdata_i[7] && !ctrl_clr)
    |=> opt_q == ($past(attr_wdata_i) & 8'hCF)); // R2

  AST_PD_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attr_wr_i && attr_addr_i == A_STAT && (attr_wdata_i[2] != stat_q[2]) && !ctrl_clr)
    |=> pin_rdy_q); // R5

  AST_PIN_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attr_rd_i && attr_addr_i == A_PIN) |=> ((attr_rdata_o & 8'hDF) == 8'h0C)); // R7

  AST_SOCK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attr_rd_i && attr_addr_i == A_SOCK) |=> attr_rdata_o == 8'h00); // R8

  AST_IRQ_INVERTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> !$past(dev_irq_i)); // R9

endmodule

bind cf_cfg_regs cf_cfg_regs_chk #(
  .ADDR_W  (ADDR_W),
  .CFG_BASE(CFG_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .attr_addr_i (attr_addr_i),
  .attr_rd_i   (attr_rd_i),
  .attr_wr_i   (attr_wr_i),
  .attr_wdata_i(attr_wdata_i),
  .attr_rdata_o(attr_rdata_o),
  .dev_irq_i   (dev_irq_i),
  .ctrl_wr_i   (ctrl_wr_i),
  .ctrl_srst_i (ctrl_srst_i),
  .host_irq_o  (host_irq_o),
  .soft_rst_o  (soft_rst_o),
  .opt_q       (opt_q),
  .stat_q      (stat_q),
  .pin_rdy_q   (pin_rdy_q)
);

// File: tb/cf_cfg_regs_bench.sv
module cf_cfg_regs_bench;

  localparam int unsigned AW   = 12;
  localparam int unsigned BASE = 'h200;
  localparam int unsigned CLEN = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] attr_addr = '0;
  logic          attr_rd = 1'b0;
  logic          attr_wr = 1'b0;
  logic [7:0]    attr_wdata = '0;
  logic [7:0]    attr_rdata;
  logic [AW-1:0] cis_addr;
  logic [7:0]    cis_data;
  logic          dev_irq = 1'b0;
  logic          ctrl_wr = 1'b0;
  logic          ctrl_nien = 1'b0;
  logic          ctrl_srst = 1'b0;
  logic          host_irq;
  logic          soft_rst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t rd_q[$];
  logic mon_pend = 1'b0;

  always #5 clk = ~clk;

  assign cis_data = cis_addr[7:0] ^ 8'hA5;

  cf_cfg_regs #(
    .ADDR_W  (AW),
    .CFG_BASE(BASE),
    .CIS_LEN (CLEN)
  ) u_cf_cfg_regs (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .attr_addr_i (attr_addr),
    .attr_rd_i   (attr_rd),
    .attr_wr_i   (attr_wr),
    .attr_wdata_i(attr_wdata),
    .attr_rdata_o(attr_rdata),
    .cis_addr_o  (cis_addr),
    .cis_data_i  (cis_data),
    .dev_irq_i   (dev_irq),
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_nien_i (ctrl_nien),
    .ctrl_srst_i (ctrl_srst),
    .host_irq_o  (host_irq),
    .soft_rst_o  (soft_rst)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: read data is valid one cycle after the strobe
  always @(posedge clk) mon_pend <= attr_rd;

  always @(negedge clk) begin
    if (mon_pend) begin
      if (rd_q.size() == 0) begin
        chk(8'hFF, 8'h00, "monitor: read with no expected item");
      end else begin
        rd_item_t it;
        it = rd_q.pop_front();
        chk(attr_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic rd(input int unsigned a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp;
    it.tag = tag;
    rd_q.push_back(it);
    attr_addr = AW'(a);
    attr_rd   = 1'b1;
    @(negedge clk);
    attr_rd   = 1'b0;
  endtask

  task automatic wr(input int unsigned a, input logic [7:0] d);
    attr_addr  = AW'(a);
    attr_wdata = d;
    attr_wr    = 1'b1;
    @(negedge clk);
    attr_wr    = 1'b0;
  endtask

  task automatic cwr(input logic nien, input logic srst);
    ctrl_nien = nien;
    ctrl_srst = srst;
    ctrl_wr   = 1'b1;
    @(negedge clk);
    ctrl_wr   = 1'b0;
    ctrl_srst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk({7'd0, soft_rst}, 8'h00, "R10 soft_rst after reset");
    chk(attr_rdata, 8'h00, "R10 rdata after reset");
    chk({7'd0, host_irq}, 8'h01, "R10/R9 host_irq after reset");
    rd(BASE + 0, 8'h00, "R10 option reset");
    rd(BASE + 2, 8'h00, "R10 status reset");
    rd(BASE + 4, 8'h0C, "R10 pin reset");

    // R1 CIS window and gap
    rd(0, 8'hA5, "R1 cis first byte");
    rd(CLEN - 1, 8'(CLEN - 1) ^ 8'hA5, "R1 cis last byte");
    rd(CLEN, 8'h00, "R1 past cis length");
    rd(BASE - 1, 8'h00, "R1 just below base");

    // R8 socket and unknown offsets
    wr(BASE + 6, 8'hFF);
    rd(BASE + 6, 8'h00, "R8 socket reads zero");
    wr(BASE + 8, 8'hFF);
    wr(BASE + 1, 8'hFF);
    rd(BASE + 8, 8'h00, "R8 unknown offset reads zero");
    rd(BASE + 0, 8'h00, "R8 option untouched by stray writes");
    rd(BASE + 2, 8'h00, "R8 status untouched by stray writes");

    // R2 option mask
    wr(BASE + 0, 8'h7F);
    rd(BASE + 0, 8'h4F, "R2 option masked 7F");
    chk({7'd0, host_irq}, 8'h01, "R9 irq with option bit7 clear");
    wr(BASE + 0, 8'h30);
    rd(BASE + 0, 8'h00, "R2 option masked 30");

    // R4 / R5 status writes
    wr(BASE + 2, 8'h00);
    rd(BASE + 4, 8'h0C, "R5 no pd change no ready");
    wr(BASE + 2, 8'h70);
    rd(BASE + 2, 8'h70, "R4 status load 70");
    rd(BASE + 4, 8'h0C, "R5 pd unchanged after 70");
    wr(BASE + 2, 8'hFF);
    rd(BASE + 2, 8'h74, "R4 status load FF masked");
    rd(BASE + 4, 8'h2C, "R5 pd change sets ready");

    // R7 pin writes
    wr(BASE + 4, 8'hFF);
    rd(BASE + 4, 8'h2C, "R7 pin write FF");
    wr(BASE + 4, 8'h00);
    rd(BASE + 4, 8'h2C, "R7 pin write 00 keeps ready");

    // R4 / R6 / R9 interrupt bit
    dev_irq = 1'b1;
    @(negedge clk);
    chk({7'd0, host_irq}, 8'h00, "R9 irq off while device requests");
    rd(BASE + 2, 8'h76, "R4 status bit1 follows device");
    wr(BASE + 2, 8'h00);
    rd(BASE + 2, 8'h02, "R4 status write keeps bit1");
    cwr(1'b1, 1'b0);
    rd(BASE + 2, 8'h00, "R6 nien masks bit1");
    dev_irq = 1'b0;
    @(negedge clk);
    chk({7'd0, host_irq}, 8'h00, "R9 nien blocks irq");
    cwr(1'b0, 1'b0);
    chk({7'd0, host_irq}, 8'h01, "R9 irq returns with nien clear");
    rd(BASE + 4, 8'h2C, "R11 ctrl write w/o srst keeps ready");

    // R3 soft reset through option register
    wr(BASE + 0, 8'h4F);
    wr(BASE + 0, 8'h81);
    chk({7'd0, soft_rst}, 8'h01, "R3 soft_rst pulse high");
    @(negedge clk);
    chk({7'd0, soft_rst}, 8'h00, "R3 soft_rst pulse one cycle");
    rd(BASE + 0, 8'h00, "R3 option cleared");
    rd(BASE + 2, 8'h00, "R3 status cleared");
    rd(BASE + 4, 8'h0C, "R3 ready cleared");

    // R11 soft reset through device control
    wr(BASE + 2, 8'h04);
    cwr(1'b1, 1'b0);
    chk({7'd0, host_irq}, 8'h00, "R9 nien set before srst");
    cwr(1'b1, 1'b1);
    chk({7'd0, soft_rst}, 8'h01, "R11 soft_rst pulse high");
    chk({7'd0, host_irq}, 8'h01, "R11 nien cleared by srst");
    @(negedge clk);
    chk({7'd0, soft_rst}, 8'h00, "R11 soft_rst pulse one cycle");
    rd(BASE + 2, 8'h00, "R11 status cleared");
    rd(BASE + 4, 8'h0C, "R11 ready cleared");

    repeat (3) @(negedge clk);
    chk(8'(rd_q.size()), 8'h00, "R1 all reads observed");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule